// File: doc/BRIEF.md
# Oversampling 4b/6b Lane Receiver

This block turns one lane of a zero-disparity 4b/6b line stream back into bytes and control symbols. Its input is the logic-level output of a differential line receiver. That input is sampled once per local clock, at eight times the transmit bit rate. No analog clock recovery is used. A small digital phase tracker watches the transitions that the balanced code guarantees, and takes each bit from the sample halfway between edges.

The recovered bits are grouped into six-bit codewords. The receiver searches the six possible bit offsets until a clean run of valid codewords containing a synchronization symbol proves the framing. While locked, it decodes data codewords into nibbles and pairs them into bytes. Control codewords are reported with a two-bit code. Unbalanced patterns raise a one-cycle violation pulse. When too many violations arrive within a short window, lock is dropped and the search starts again.

Top module: `os4b6b_rx`

## Requirements
- R1: The input is sampled every clock at eight samples per bit. Each bit is taken at phase count 4 of a free-running 0..7 counter. An edge seen at count 1..3 holds the counter for a clock, an edge at count 5..7 advances it by two, and any other clock advances it by one. Reception stays error-free when the transmitter stretches one bit in eight to 9 samples, shrinks one bit in eight to 7 samples, or when a one-sample glitch sits inside a bit.
- R2: Codewords are six bits long and are sent most significant bit first.
- R3: The 16 three-ones patterns that are not control symbols map to nibbles 0..15 in ascending numeric order of the pattern (001011 is nibble 0, 110100 is nibble 15).
- R4: The control patterns 000111, 111000, 001110 and 110001 are reported on ctrl_o as codes 0, 1, 2 and 3, with a one-cycle ctrl_vld_o. Code 0 is the synchronization symbol.
- R5: Two data codewords form a byte, the first giving bits 3:0 and the second giving bits 7:4. byte_vld_o pulses once per byte, and byte_o holds its value between strobes.
- R6: A synchronization symbol discards any pending lower nibble, so the next data codeword is a lower nibble. The other control symbols leave the pending nibble in place.
- R7: While locked, a codeword whose number of ones is not three gives a one-cycle code_err_o and discards any pending lower nibble. At most one of the three strobes is high in any cycle.
- R8: While unlocked, every invalid codeword slips the framing by one bit. lock_o rises at the end of a run of at least 16 consecutive valid codewords at one offset that contains a synchronization symbol. The codeword that completes the run is not reported.
- R9: While locked, when the current codeword together with the 15 before it holds 4 invalid ones, code_err_o pulses for it, lock_o falls in the same cycle, and the search restarts. Fewer than 4 invalid codewords in any such window keep lock.
- R10: No strobe is produced while unlocked.
- R11: In reset, lock_o, every strobe and byte_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, eight times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Line receiver output |
| byte_o | output | 8 | Reassembled byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| ctrl_o | output | 2 | Control symbol code |
| ctrl_vld_o | output | 1 | One-cycle strobe for ctrl_o |
| lock_o | output | 1 | Word framing is established |
| code_err_o | output | 1 | One-cycle pulse for an invalid codeword |

## Verification
A repeating preamble of one synchronization symbol and seven idles is sent from an unknown starting phase. It shows whether the offset search rejects every wrong framing and finds the right one. Bytes covering all sixteen nibbles are sent with exact bit timing, then with stretched bits, shortened bits and in-bit glitches, which separates a phase tracker that follows drift from one that loses bits. Mixed sequences of synchronization, idle and unbalanced codewords placed between nibbles show how the nibble phase is reset or kept. Violations spread across and packed inside a sixteen-word window tell a sliding window apart from a simple counter, and the bench then checks that the receiver locks again.

// File: rtl/os4b6b_rx.sv
module os4b6b_rx #(
  parameter int OSR        = 8,
  parameter int LOCK_RUN   = 16,
  parameter int LOSS_WIN   = 16,
  parameter int LOSS_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic [1:0] ctrl_o,
  output logic       ctrl_vld_o,
  output logic       lock_o,
  output logic       code_err_o
);
  localparam int PW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int RW   = $clog2(LOCK_RUN + 1);
  localparam int EW   = $clog2(LOSS_WIN + 1);

  logic              line_s, line_q;
  logic [PW-1:0]     ph;
  logic [2:0]        bcnt;
  logic [4:0]        sh;
  logic [RW-1:0]     run;
  logic              seen, nib_hi;
  logic [3:0]        lo_nib;
  logic [LOSS_WIN-2:0] hist;
  logic [EW-1:0]     errs;
  logic              is_data, is_ctrl;
  logic [3:0]        nib;
  logic [1:0]        cc;

  wire          edge_w   = line_s ^ line_q;
  wire          bit_stb  = (ph == PW'(HALF));
  wire [5:0]    word     = {sh, line_s};
  wire          word_stb = bit_stb && (bcnt == 3'd5);
  wire          valid    = is_data | is_ctrl;
  wire          is_sync  = is_ctrl && (cc == 2'd0);
  wire [RW-1:0] run_nx   = (run == RW'(LOCK_RUN)) ? run : run + RW'(1);
  wire          seen_nx  = seen | is_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_s <= 1'b0;
      line_q <= 1'b0;
      ph     <= '0;
    end else begin
      line_s <= line_i;
      line_q <= line_s;
      if (edge_w && ph != '0 && ph < PW'(HALF))
        ph <= ph;
      else if (edge_w && ph > PW'(HALF))
        ph <= ph + PW'(2);
      else
        ph <= ph + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      sh   <= '0;
    end else if (bit_stb) begin
      sh <= word[4:0];
      if (word_stb)
        bcnt <= (!lock_o && !valid) ? 3'd1 : 3'd0;
      else
        bcnt <= bcnt + 3'd1;
    end
  end

  always_comb begin
    is_data = 1'b1;
    is_ctrl = 1'b0;
    nib     = '0;
    cc      = '0;
    case (word)
      6'b001011: nib = 4'd0;
      6'b001101: nib = 4'd1;
      6'b010011: nib = 4'd2;
      6'b010101: nib = 4'd3;
      6'b010110: nib = 4'd4;
      6'b011001: nib = 4'd5;
      6'b011010: nib = 4'd6;
      6'b011100: nib = 4'd7;
      6'b100011: nib = 4'd8;
      6'b100101: nib = 4'd9;
      6'b100110: nib = 4'd10;
      6'b101001: nib = 4'd11;
      6'b101010: nib = 4'd12;
      6'b101100: nib = 4'd13;
      6'b110010: nib = 4'd14;
      6'b110100: nib = 4'd15;
      6'b000111: begin is_data = 1'b0; is_ctrl = 1'b1; cc = 2'd0; end
      6'b111000: begin is_data = 1'b0; is_ctrl = 1'b1; cc = 2'd1; end
      6'b001110: begin is_data = 1'b0; is_ctrl = 1'b1; cc = 2'd2; end
      6'b110001: begin is_data = 1'b0; is_ctrl = 1'b1; cc = 2'd3; end
      default:   is_data = 1'b0;
    endcase
  end

  always_comb begin
    errs = EW'(!valid);
    for (int i = 0; i < LOSS_WIN - 1; i++)
      errs = errs + EW'(hist[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_o <= 1'b0;
      run    <= '0;
      seen   <= 1'b0;
      hist   <= '0;
    end else if (word_stb) begin
      if (!lock_o) begin
        if (valid) begin
          run  <= run_nx;
          seen <= seen_nx;
          if (run_nx == RW'(LOCK_RUN) && seen_nx) begin
            lock_o <= 1'b1;
            hist   <= '0;
          end
        end else begin
          run  <= '0;
          seen <= 1'b0;
        end
      end else begin
        hist <= {hist[LOSS_WIN-3:0], !valid};
        if (errs >= EW'(LOSS_LIMIT)) begin
          lock_o <= 1'b0;
          run    <= '0;
          seen   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      ctrl_o     <= '0;
      ctrl_vld_o <= 1'b0;
      code_err_o <= 1'b0;
      nib_hi     <= 1'b0;
      lo_nib     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      ctrl_vld_o <= 1'b0;
      code_err_o <= 1'b0;
      if (!lock_o) begin
        nib_hi <= 1'b0;
      end else if (word_stb) begin
        if (is_data) begin
          if (nib_hi) begin
            byte_o     <= {nib, lo_nib};
            byte_vld_o <= 1'b1;
            nib_hi     <= 1'b0;
          end else begin
            lo_nib <= nib;
            nib_hi <= 1'b1;
          end
        end else if (is_ctrl) begin
          ctrl_o     <= cc;
          ctrl_vld_o <= 1'b1;
          if (cc == 2'd0) nib_hi <= 1'b0;
        end else begin
          code_err_o <= 1'b1;
          nib_hi     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/os4b6b_rx_chk.sv
module os4b6b_rx_chk #(
  parameter int OSR = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(OSR)-1:0]   ph,
  input logic                     lock,
  input logic                     byte_vld,
  input logic                     ctrl_vld,
  input logic                     code_err,
  input logic [7:0]               byte_q,
  input logic [1:0]               ctrl_q
);
  localparam int PW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  p_phase_slew_r1: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(ph - $past(ph)) <= PW'(2));

  p_one_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PW'(HALF)) |=> (ph != PW'(HALF)));

  p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> $stable(byte_q));

  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_vld |-> $stable(ctrl_q));

  p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, ctrl_vld, code_err}));

  p_err_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> $past(lock));

  p_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> code_err);

  p_quiet_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || ctrl_vld) |-> lock);
endmodule

bind os4b6b_rx os4b6b_rx_chk #(.OSR(OSR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .lock(lock_o),
  .byte_vld(byte_vld_o), .ctrl_vld(ctrl_vld_o), .code_err(code_err_o),
  .byte_q(byte_o), .ctrl_q(ctrl_o)
);

// File: tb/os4b6b_rx_tb_top.sv
module os4b6b_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, line_w = 1'b0;
  logic [7:0] byte_o;
  logic [1:0] ctrl_o;
  logic byte_vld_o, ctrl_vld_o, lock_o, code_err_o;

  always #5 clk = ~clk;

  os4b6b_rx dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_w),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .ctrl_o(ctrl_o), .ctrl_vld_o(ctrl_vld_o),
    .lock_o(lock_o), .code_err_o(code_err_o)
  );

  typedef struct packed { int kind; int val; } tok_t;
  tok_t q[$];
  int n_vec = 0, n_bad = 0;
  int code_of[16];
  int ctrl_tab[4] = '{7, 56, 14, 49};
  bit aligned = 0, tx_hi = 0, prev_lock = 0, done = 0;
  int tx_lo = 0, mode = 0, bitno = 0, words_sent = 0, lock_words = -1;
  string sect = "R11";

  task automatic check(bit ok, string rq, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", sect, rq, act, exp);
    end
  endtask

  function automatic int ctrl_idx(int w);
    for (int i = 0; i < 4; i++) if (ctrl_tab[i] == w) return i;
    return -1;
  endfunction

  function automatic int data_idx(int w);
    for (int i = 0; i < 16; i++) if (code_of[i] == w) return i;
    return -1;
  endfunction

  task automatic push(int k, int v);
    tok_t t;
    t.kind = k; t.val = v;
    q.push_back(t);
    if (!aligned && q.size() > 3) void'(q.pop_front());
  endtask

  task automatic send_bit(bit b, bit glitch);
    int len;
    len = 8;
    if (mode == 1 && bitno % 8 == 7) len = 9;
    if (mode == 2 && bitno % 8 == 7) len = 7;
    bitno++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      line_w = (glitch && i == 1) ? ~b : b;
    end
  endtask

  // R2: six bits, most significant first; expected token modelled from R3..R7
  task automatic send_word(int w, bit glitch);
    int c, d;
    logic [5:0] wb;
    wb = 6'(w);
    c = ctrl_idx(w);
    d = data_idx(w);
    words_sent++;
    if (c >= 0) begin
      push(1, c);
      if (c == 0) tx_hi = 0;
    end else if (d >= 0) begin
      if (tx_hi) begin push(0, d * 16 + tx_lo); tx_hi = 0; end
      else begin tx_lo = d; tx_hi = 1; end
    end else begin
      push(2, 0);
      tx_hi = 0;
    end
    for (int i = 5; i >= 0; i--) send_bit(wb[i], glitch && i == 3);
  endtask

  task automatic send_ctrl(int c); send_word(ctrl_tab[c], 1'b0); endtask
  task automatic send_nib(int n); send_word(code_of[n], 1'b0); endtask
  task automatic send_byte(int b, bit g);
    send_word(code_of[b % 16], g);
    send_word(code_of[b / 16], g);
  endtask

  task automatic preamble_until_aligned();
    for (int g = 0; g < 60 && !aligned; g++) begin
      send_ctrl(0);
      for (int i = 0; i < 7; i++) send_ctrl(1);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (byte_vld_o || ctrl_vld_o || code_err_o) begin
        int k, v;
        tok_t t;
        k = byte_vld_o ? 0 : (ctrl_vld_o ? 1 : 2);
        v = byte_vld_o ? int'(byte_o) : (ctrl_vld_o ? int'(ctrl_o) : 0);
        if (!lock_o && !prev_lock) begin
          check(1'b0, "R10 strobe while unlocked", 1, 0);
        end else if (!aligned) begin
          if (k == 1 && v == 0) begin
            bit found;
            found = 0;
            while (q.size() > 0 && !found) begin
              t = q.pop_front();
              if (t.kind == 1 && t.val == 0) found = 1;
            end
            aligned = found;
            check(found, "R4 sync symbol", v, 0);
          end
        end else if (q.size() == 0) begin
          check(1'b0, "R5 unexpected output", k * 256 + v, -1);
        end else begin
          t = q.pop_front();
          check(t.kind == k && t.val == v,
                (t.kind == 0) ? "R2 R3 R5 byte" : ((t.kind == 1) ? "R2 R4 control" : "R7 violation"),
                k * 256 + v, t.kind * 256 + t.val);
        end
      end
      if (lock_o && !prev_lock && lock_words < 0) lock_words = words_sent;
      if (!lock_o) aligned = 0;
      prev_lock = lock_o;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int idx;
    idx = 0;
    for (int w = 0; w < 64; w++)
      if ($countones(6'(w)) == 3 && ctrl_idx(w) < 0) begin
        code_of[idx] = w;
        idx++;
      end

    repeat (4) @(negedge clk);
    check(lock_o == 1'b0, "R11 lock", int'(lock_o), 0);
    check({byte_vld_o, ctrl_vld_o, code_err_o} == 3'b000, "R11 strobes",
          int'({byte_vld_o, ctrl_vld_o, code_err_o}), 0);
    check(byte_o == 8'h00, "R11 byte", int'(byte_o), 0);
    rst_n = 1'b1;

    sect = "R8";
    preamble_until_aligned();
    check(aligned, "R8 first lock", int'(aligned), 1);
    check(lock_words >= 16, "R8 run length", lock_words, 16);

    sect = "R3";
    send_ctrl(0);
    for (int i = 0; i < 16; i++) send_byte((15 - i) * 16 + i, 1'b0);
    send_ctrl(2);
    send_ctrl(3);

    sect = "R6";
    send_nib(5); send_ctrl(0); send_nib(9); send_nib(3);
    send_nib(2); send_ctrl(1); send_nib(7);
    send_nib(10); send_ctrl(3); send_nib(1);

    sect = "R7";
    send_nib(4); send_word(6'b110111, 1'b0); send_nib(6); send_nib(1);
    send_word(6'b000000, 1'b0); send_ctrl(0);

    sect = "R1";
    mode = 1;
    for (int i = 0; i < 24; i++) send_byte((i * 37 + 11) % 256, 1'b0);
    check(lock_o == 1'b1, "R1 slow transmitter", int'(lock_o), 1);
    mode = 2;
    for (int i = 0; i < 24; i++) send_byte((i * 53 + 7) % 256, 1'b0);
    check(lock_o == 1'b1, "R1 fast transmitter", int'(lock_o), 1);
    mode = 0;
    for (int i = 0; i < 12; i++) send_byte((i * 29 + 200) % 256, 1'b1);
    check(lock_o == 1'b1, "R1 glitches", int'(lock_o), 1);

    sect = "R9";
    send_ctrl(0);
    send_word(6'b111111, 1'b0);
    for (int i = 0; i < 4; i++) send_ctrl(1);
    send_word(6'b110111, 1'b0);
    for (int i = 0; i < 4; i++) send_ctrl(1);
    send_word(6'b111011, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(i * 17, 1'b0);
    check(lock_o == 1'b1, "R9 three spread", int'(lock_o), 1);
    send_word(6'b110111, 1'b0);
    send_ctrl(1);
    check(lock_o == 1'b1, "R9 window slid", int'(lock_o), 1);
    send_word(6'b110111, 1'b0);
    send_word(6'b111011, 1'b0);
    send_ctrl(1);
    check(lock_o == 1'b1, "R9 three in window", int'(lock_o), 1);
    send_word(6'b110111, 1'b0);
    send_ctrl(1);
    check(lock_o == 1'b0, "R9 fourth drops lock", int'(lock_o), 0);

    sect = "R8";
    preamble_until_aligned();
    check(aligned, "R8 relock", int'(aligned), 1);
    send_ctrl(0);
    for (int i = 0; i < 4; i++) send_byte(i * 64 + 33, 1'b0);
    send_ctrl(1);
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R5 all tokens delivered", q.size(), 0);
    finish_run();
  end
endmodule